// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the write-side command decoder of a parallel NOR flash device. A host writes words over a simple slave port (byte address, write data, write strobe). The sequencer recognises the two-step unlock pattern and the command code that follows it. It then moves into program, erase, autoselect, CFI query or unlock-bypass operation. Program cycles update an internal word store. Erase starts are handed to an external erase controller as one-cycle request pulses, and that controller signals completion with a done pulse.

The bus word width is a build-time parameter of 1, 2 or 4 bytes. Command matching uses a word-granular address key, so the unlock addresses keep their meaning at every width. A read port returns stored words with one cycle of latency. The current sequencer state and the bypass flag are brought out so that a read multiplexer, for example one serving identification or query data, can follow the mode. All state changes happen on the rising clock edge. An active-low synchronous reset returns the machine to array-read state with bypass cleared.

Top module: `nfc_cmd_seq`

## Requirements
- R1: After reset, `seq_state` is 0 (array read), `bypass_on` is 0, both erase request outputs are 0 and `rd_data` is 0.
- R2: The unlock pattern is data 0xAA written at key UNLOCK_A0 (default 0x555), then data 0x55 at key UNLOCK_A1 (default 0x2AA). It leads from state 0 through state 1 to state 2 (command). A wrong data byte or a wrong key at either step returns the machine to state 0.
- R3: In state 2 without bypass, a write at key UNLOCK_A0 with code 0x80 goes to state 5, code 0x90 goes to state 3 (autoselect) and code 0xA0 goes to state 4 (program). Any other code, or a write at another key, goes to state 0.
- R4: The key is the byte address shifted right by log2(BUS_BYTES), keeping only its low 11 bits. Higher address bits and the byte lanes inside a word do not affect matching.
- R5: In state 0, code 0x98 at key 0x55 enters state 9 (query). Any following write returns the machine to state 0.
- R6: In state 3, code 0x98 at key 0x55 enters state 10 (query from autoselect). A 0xF0 write in state 10 returns to state 3, and the bypass flag is kept.
- R7: A write with code 0xF0 returns the machine to state 0 and clears bypass from every state except 4, 8 and 10.
- R8: A write in state 4 stores the bitwise AND of the old word and the written data at the addressed word. This applies to every data value, 0xF0 included. The machine then leaves state 4.
- R9: Code 0x20 in state 2 sets `bypass_on` and keeps state 2. While bypass is set, state 2 accepts commands at any key, and a completed program returns the machine to state 2.
- R10: In state 3 with bypass set, code 0x00 returns the machine to state 0 and clears bypass.
- R11: After code 0x80, a second unlock takes the machine through states 5, 6 and 7. In state 7, code 0x10 at key UNLOCK_A0 pulses `erase_chip_req`, and code 0x30 at any key pulses `erase_sector_req` with `erase_addr` set to the word address. Either command enters state 8. Each pulse lasts one cycle, and the two are never high together.
- R12: State 8 (erasing) ignores every write, 0xF0 included, until `erase_done` is high. The machine then goes to state 2 if bypass is set and to state 0 otherwise.
- R13: Any write that does not match the expected step clears `bypass_on` and returns the machine to state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| addr | input | ADDR_W | Byte address of the write |
| wdata | input | 8*BUS_BYTES | Write data; the low byte is the command code |
| erase_done | input | 1 | Completion pulse from the erase controller |
| rd_addr | input | ADDR_W | Byte address of the array read |
| rd_data | output | 8*BUS_BYTES | Stored word, one cycle after rd_addr |
| seq_state | output | 4 | Sequencer state, encoded as in the requirements |
| bypass_on | output | 1 | Unlock-bypass flag |
| erase_chip_req | output | 1 | One-cycle chip erase request |
| erase_sector_req | output | 1 | One-cycle sector erase request |
| erase_addr | output | ADDR_W-log2(BUS_BYTES) | Word address of the sector erase |

## Verification
The hardest situation to reach from the ports is query mode entered from autoselect while bypass is set. Getting there takes an unlock, code 0x20, code 0x90 at an arbitrary key and then 0x98 at key 0x55, so that a 0xF0 must return to autoselect without touching the bypass flag. Erase under bypass is similarly deep. The bench drives both paths through scripted write sequences, releases erase with a timed done pulse, and compares every output each cycle against a behavioural model that tracks the mode, the flag and a copy of the word store.

// File: rtl/nfc_pkg.sv
// Package: shared state encoding and command codes of the NOR flash
// command sequencer. Assumes an 8-bit command in the low data byte.
package nfc_pkg;

    typedef enum logic [3:0] {
        ST_READ     = 4'd0,
        ST_UNL1     = 4'd1,
        ST_CMD      = 4'd2,
        ST_AUTOSEL  = 4'd3,
        ST_PROG     = 4'd4,
        ST_ERS_UNL0 = 4'd5,
        ST_ERS_UNL1 = 4'd6,
        ST_ERS_CMD  = 4'd7,
        ST_ERASING  = 4'd8,
        ST_QUERY    = 4'd9,
        ST_AS_QUERY = 4'd10
    } seq_st_t;

    localparam logic [7:0] CODE_UNLOCK_1 = 8'hAA;
    localparam logic [7:0] CODE_UNLOCK_2 = 8'h55;
    localparam logic [7:0] CODE_BYPASS   = 8'h20;
    localparam logic [7:0] CODE_ERASE    = 8'h80;
    localparam logic [7:0] CODE_AUTOSEL  = 8'h90;
    localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
    localparam logic [7:0] CODE_QUERY    = 8'h98;
    localparam logic [7:0] CODE_RESET    = 8'hF0;
    localparam logic [7:0] CODE_CHIP_ERS = 8'h10;
    localparam logic [7:0] CODE_SECT_ERS = 8'h30;
    localparam logic [7:0] CODE_BYP_EXIT = 8'h00;

    localparam int         KEY_W         = 11;
    localparam logic [10:0] QUERY_KEY    = 11'h055;

endpackage

// File: rtl/nfc_addr_map.sv
// Module: converts a byte address into the word address and the 11-bit
// command key. Assumes BUS_BYTES is 1, 2 or 4; the width picks the shift.
module nfc_addr_map #(
    parameter int ADDR_W    = 16,
    parameter int BUS_BYTES = 2,
    parameter int SHIFT     = (BUS_BYTES == 4) ? 2 : ((BUS_BYTES == 2) ? 1 : 0),
    parameter int WORD_AW   = ADDR_W - SHIFT
) (
    input  logic [ADDR_W-1:0]           byte_addr,
    output logic [WORD_AW-1:0]          word_addr,
    output logic [nfc_pkg::KEY_W-1:0]   cmd_key
);
    localparam int KW = nfc_pkg::KEY_W;

    // Word address: drop the byte-lane bits for the configured width.
    generate
        if (SHIFT == 0) begin : g_w8
            assign word_addr = byte_addr;
        end else begin : g_wide
            assign word_addr = byte_addr[ADDR_W-1:SHIFT];
        end
    endgenerate

    // Command key: low KEY_W bits of the word address, zero-padded if narrow.
    generate
        if (WORD_AW >= KW) begin : g_key_cut
            assign cmd_key = word_addr[KW-1:0];
        end else begin : g_key_pad
            assign cmd_key = {{(KW-WORD_AW){1'b0}}, word_addr};
        end
    endgenerate

endmodule

// File: rtl/nfc_seq_fsm.sv
// Module: the write-cycle state machine. Decodes unlock steps, command codes,
// bypass and query entry, and emits program enable and erase requests.
// Assumes one write per wr_en cycle and that erase_done only matters while
// erasing; erase_done wins over a same-cycle write.
module nfc_seq_fsm #(
    parameter int          WORD_AW   = 15,
    parameter logic [10:0] UNLOCK_A0 = 11'h555,
    parameter logic [10:0] UNLOCK_A1 = 11'h2AA
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [7:0]                  code,
    input  logic [nfc_pkg::KEY_W-1:0]   cmd_key,
    input  logic [WORD_AW-1:0]          word_addr,
    input  logic                        erase_done,
    output nfc_pkg::seq_st_t            state,
    output logic                        bypass,
    output logic                        prog_en,
    output logic                        chip_req,
    output logic                        sect_req,
    output logic [WORD_AW-1:0]          sect_addr
);
    import nfc_pkg::*;

    seq_st_t st_n;
    logic    byp_n;
    logic    chip_n;
    logic    sect_n;
    logic    go_read;
    logic    at_a0;
    logic    at_a1;

    assign at_a0 = (cmd_key == UNLOCK_A0);
    assign at_a1 = (cmd_key == UNLOCK_A1);

    // Program enable: a write seen while waiting for program data.
    assign prog_en = wr_en && (state == ST_PROG);

    // Next-state decode of one bus write or an erase completion.
    always_comb begin
        st_n    = state;
        byp_n   = bypass;
        chip_n  = 1'b0;
        sect_n  = 1'b0;
        go_read = 1'b0;
        if (erase_done && state == ST_ERASING) begin
            st_n = bypass ? ST_CMD : ST_READ;
        end else if (wr_en) begin
            if (code == CODE_RESET && state != ST_PROG && state != ST_ERASING) begin
                if (state == ST_AS_QUERY) st_n = ST_AUTOSEL;
                else                      go_read = 1'b1;
            end else begin
                case (state)
                    ST_READ: begin
                        if (cmd_key == QUERY_KEY && code == CODE_QUERY) st_n = ST_QUERY;
                        else if (at_a0 && code == CODE_UNLOCK_1)        st_n = ST_UNL1;
                        else                                            go_read = 1'b1;
                    end
                    ST_UNL1: begin
                        if (at_a1 && code == CODE_UNLOCK_2) st_n = ST_CMD;
                        else                                go_read = 1'b1;
                    end
                    ST_CMD: begin
                        if (!bypass && !at_a0) begin
                            go_read = 1'b1;
                        end else begin
                            case (code)
                                CODE_BYPASS:  byp_n = 1'b1;
                                CODE_ERASE:   st_n  = ST_ERS_UNL0;
                                CODE_AUTOSEL: st_n  = ST_AUTOSEL;
                                CODE_PROGRAM: st_n  = ST_PROG;
                                default:      go_read = 1'b1;
                            endcase
                        end
                    end
                    ST_AUTOSEL: begin
                        if (bypass && code == CODE_BYP_EXIT)                 go_read = 1'b1;
                        else if (cmd_key == QUERY_KEY && code == CODE_QUERY) st_n = ST_AS_QUERY;
                        else                                                 go_read = 1'b1;
                    end
                    ST_PROG: begin
                        st_n = bypass ? ST_CMD : ST_READ;
                    end
                    ST_ERS_UNL0: begin
                        if (at_a0 && code == CODE_UNLOCK_1) st_n = ST_ERS_UNL1;
                        else                                go_read = 1'b1;
                    end
                    ST_ERS_UNL1: begin
                        if (at_a1 && code == CODE_UNLOCK_2) st_n = ST_ERS_CMD;
                        else                                go_read = 1'b1;
                    end
                    ST_ERS_CMD: begin
                        if (at_a0 && code == CODE_CHIP_ERS) begin
                            chip_n = 1'b1;
                            st_n   = ST_ERASING;
                        end else if (code == CODE_SECT_ERS) begin
                            sect_n = 1'b1;
                            st_n   = ST_ERASING;
                        end else begin
                            go_read = 1'b1;
                        end
                    end
                    ST_ERASING: begin
                        st_n = ST_ERASING;
                    end
                    default: go_read = 1'b1;
                endcase
            end
            if (go_read) begin
                st_n  = ST_READ;
                byp_n = 1'b0;
            end
        end
    end

    // State, bypass flag and one-cycle erase request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_READ;
            bypass    <= 1'b0;
            chip_req  <= 1'b0;
            sect_req  <= 1'b0;
            sect_addr <= '0;
        end else begin
            state    <= st_n;
            bypass   <= byp_n;
            chip_req <= chip_n;
            sect_req <= sect_n;
            if (sect_n) sect_addr <= word_addr;
        end
    end

endmodule

// File: rtl/nfc_word_store.sv
// Module: synchronous word store standing in for the flash array. Program
// writes the AND of the old word and new data; reads take one cycle.
// Assumes reset models a fully erased array (all ones).
module nfc_word_store #(
    parameter int DW     = 16,
    parameter int MEM_AW = 8,
    parameter int DEPTH  = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [MEM_AW-1:0] prog_idx,
    input  logic [DW-1:0]     prog_data,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [DW-1:0]     rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Array update: erased fill on reset, bit-clearing program otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (prog_en) begin
            mem[prog_idx] <= mem[prog_idx] & prog_data;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[rd_idx];
    end

endmodule

// File: rtl/nfc_cmd_seq.sv
// Module: top of the NOR flash command sequencer. Maps the write address,
// runs the command state machine and owns the word store. Assumes
// MEM_AW <= word address width; the store mirrors across the address space.
module nfc_cmd_seq #(
    parameter int          ADDR_W    = 16,
    parameter int          BUS_BYTES = 2,
    parameter int          MEM_AW    = 8,
    parameter logic [10:0] UNLOCK_A0 = 11'h555,
    parameter logic [10:0] UNLOCK_A1 = 11'h2AA,
    parameter int          DW        = 8 * BUS_BYTES,
    parameter int          SHIFT     = (BUS_BYTES == 4) ? 2 : ((BUS_BYTES == 2) ? 1 : 0),
    parameter int          WORD_AW   = ADDR_W - SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DW-1:0]      wdata,
    input  logic               erase_done,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic [3:0]         seq_state,
    output logic               bypass_on,
    output logic               erase_chip_req,
    output logic               erase_sector_req,
    output logic [WORD_AW-1:0] erase_addr
);
    logic [WORD_AW-1:0]        wr_word;
    logic [nfc_pkg::KEY_W-1:0] wr_key;
    logic [WORD_AW-1:0]        rd_word;
    logic [nfc_pkg::KEY_W-1:0] rd_key;
    logic                      prog_en;
    nfc_pkg::seq_st_t          st;

    nfc_addr_map #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_wmap (
        .byte_addr (addr),
        .word_addr (wr_word),
        .cmd_key   (wr_key)
    );

    nfc_addr_map #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_rmap (
        .byte_addr (rd_addr),
        .word_addr (rd_word),
        .cmd_key   (rd_key)
    );

    nfc_seq_fsm #(
        .WORD_AW   (WORD_AW),
        .UNLOCK_A0 (UNLOCK_A0),
        .UNLOCK_A1 (UNLOCK_A1)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .code       (wdata[7:0]),
        .cmd_key    (wr_key),
        .word_addr  (wr_word),
        .erase_done (erase_done),
        .state      (st),
        .bypass     (bypass_on),
        .prog_en    (prog_en),
        .chip_req   (erase_chip_req),
        .sect_req   (erase_sector_req),
        .sect_addr  (erase_addr)
    );

    nfc_word_store #(.DW(DW), .MEM_AW(MEM_AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_idx  (wr_word[MEM_AW-1:0]),
        .prog_data (wdata),
        .rd_idx    (rd_word[MEM_AW-1:0]),
        .rd_data   (rd_data)
    );

    // The read key is not used for array reads.
    logic unused_rd_key;
    assign unused_rd_key = ^rd_key;

    assign seq_state = st;

endmodule

// File: rtl/nfc_cmd_seq_chk.sv
// Module: property checker for nfc_cmd_seq, attached with bind below.
// Assumes the state encoding of nfc_pkg.
module nfc_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] code,
    input logic       erase_done,
    input logic [3:0] seq_state,
    input logic       bypass_on,
    input logic       erase_chip_req,
    input logic       erase_sector_req
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (seq_state == 4'd0 && !bypass_on && !erase_chip_req && !erase_sector_req));

    // R11
    erase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_chip_req, erase_sector_req}));

    // R11
    sector_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_sector_req |-> $past(seq_state) == 4'd7);

    // R12
    erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 4'd8 && !erase_done) |=> seq_state == 4'd8);

    // R9
    bypass_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bypass_on) |-> $past(seq_state) == 4'd2);

    // R7
    reset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && code == 8'hF0 && seq_state != 4'd4 && seq_state != 4'd8
         && seq_state != 4'd10) |=> (seq_state == 4'd0 && !bypass_on));

    // R6
    query_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && code == 8'hF0 && seq_state == 4'd10) |=> seq_state == 4'd3);

endmodule

bind nfc_cmd_seq nfc_cmd_seq_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .code             (wdata[7:0]),
    .erase_done       (erase_done),
    .seq_state        (seq_state),
    .bypass_on        (bypass_on),
    .erase_chip_req   (erase_chip_req),
    .erase_sector_req (erase_sector_req)
);

// File: tb/tb_nfc_cmd_seq.sv
`timescale 1ns/1ps
module tb_nfc_cmd_seq;
    localparam int ADDR_W = 16;
    localparam int DW     = 16;
    localparam int WAW    = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic              erase_done = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DW-1:0]     rd_data;
    logic [3:0]        seq_state;
    logic              bypass_on;
    logic              erase_chip_req;
    logic              erase_sector_req;
    logic [WAW-1:0]    erase_addr;

    nfc_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .erase_done(erase_done), .rd_addr(rd_addr), .rd_data(rd_data),
        .seq_state(seq_state), .bypass_on(bypass_on),
        .erase_chip_req(erase_chip_req), .erase_sector_req(erase_sector_req),
        .erase_addr(erase_addr)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    bit    cmp_on = 0;
    bit    done = 0;
    string cur_req = "R1";

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model: mode number, flag and word store.
    int          m_st;
    bit          m_byp;
    bit          m_chip, m_sec;
    int          m_eaddr;
    logic [15:0] m_mem [256];
    logic [15:0] m_rd;

    always @(posedge clk) begin
        int  key;
        int  c;
        bit  bad;
        if (!rst_n) begin
            m_st = 0; m_byp = 0; m_chip = 0; m_sec = 0; m_eaddr = 0; m_rd = 0;
            foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
        end else begin
            m_rd   = m_mem[(rd_addr >> 1) & 255];
            m_chip = 0;
            m_sec  = 0;
            key    = (addr >> 1) & 'h7FF;
            c      = wdata[7:0];
            bad    = 0;
            if (erase_done && m_st == 8) begin
                m_st = m_byp ? 2 : 0;
            end else if (wr_en) begin
                if (c == 'hF0 && !(m_st inside {4, 8})) begin
                    if (m_st == 10) m_st = 3; else bad = 1;
                end else if (m_st == 0) begin
                    if (key == 'h55 && c == 'h98) m_st = 9;
                    else if (key == 'h555 && c == 'hAA) m_st = 1;
                    else bad = 1;
                end else if (m_st == 1 || m_st == 6) begin
                    if (key == 'h2AA && c == 'h55) m_st = m_st + 1; else bad = 1;
                end else if (m_st == 5) begin
                    if (key == 'h555 && c == 'hAA) m_st = 6; else bad = 1;
                end else if (m_st == 2) begin
                    if (!m_byp && key != 'h555) bad = 1;
                    else if (c == 'h20) m_byp = 1;
                    else if (c == 'h80) m_st = 5;
                    else if (c == 'h90) m_st = 3;
                    else if (c == 'hA0) m_st = 4;
                    else bad = 1;
                end else if (m_st == 3) begin
                    if (!(m_byp && c == 0) && key == 'h55 && c == 'h98) m_st = 10;
                    else bad = 1;
                end else if (m_st == 4) begin
                    m_mem[key & 255] = m_mem[key & 255] & wdata;
                    m_st = m_byp ? 2 : 0;
                end else if (m_st == 7) begin
                    if (key == 'h555 && c == 'h10) begin m_chip = 1; m_st = 8; end
                    else if (c == 'h30) begin m_sec = 1; m_eaddr = addr >> 1; m_st = 8; end
                    else bad = 1;
                end else if (m_st != 8) begin
                    bad = 1;
                end
                if (bad) begin m_st = 0; m_byp = 0; end
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(cur_req, "seq_state", seq_state, m_st);
            chk(cur_req, "bypass_on", bypass_on, m_byp);
            chk(cur_req, "erase_chip_req", erase_chip_req, m_chip);
            chk(cur_req, "erase_sector_req", erase_sector_req, m_sec);
            chk(cur_req, "rd_data", rd_data, m_rd);
            if (m_sec) chk(cur_req, "erase_addr", erase_addr, m_eaddr);
        end
    end

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic unlock();
        wr(16'h0AAA, 16'h00AA);
        wr(16'h0554, 16'h0055);
    endtask

    task automatic finish_erase();
        erase_done = 1;
        @(negedge clk);
        erase_done = 0;
    endtask

    task automatic rd(input logic [15:0] a);
        rd_addr = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "reset seq_state", seq_state, 0);
        chk("R1", "reset bypass", bypass_on, 0);
        chk("R1", "reset rd_data", rd_data, 0);
        rst_n = 1; cmp_on = 1;
        @(negedge clk);

        cur_req = "R2";
        unlock();
        chk("R2", "after unlock", seq_state, 2);
        cur_req = "R3";
        wr(16'h0AAA, 16'h0077);
        chk("R3", "bad code", seq_state, 0);
        cur_req = "R2";
        wr(16'h0AAC, 16'h00AA);
        chk("R2", "wrong unlock key", seq_state, 0);
        wr(16'h0AAA, 16'h00AA);
        wr(16'h0554, 16'h0056);
        chk("R2", "wrong unlock data", seq_state, 0);
        cur_req = "R3";
        unlock();
        wr(16'h0554, 16'h00A0);
        chk("R3", "command off key", seq_state, 0);

        cur_req = "R4";
        wr(16'h1AAB, 16'h00AA);
        wr(16'hF555, 16'h0055);
        chk("R4", "aliased unlock", seq_state, 2);
        cur_req = "R8";
        wr(16'h0AAA, 16'h00A0);
        chk("R3", "program entry", seq_state, 4);
        wr(16'h0020, 16'h0F3C);
        chk("R8", "after program", seq_state, 0);
        rd(16'h0020);
        chk("R8", "programmed word", rd_data, 16'h0F3C);
        unlock(); wr(16'h0AAA, 16'h00A0);
        wr(16'h0020, 16'hF0F0);
        rd(16'h0020);
        chk("R8", "AND with F0 data", rd_data, 16'h0030);
        chk("R7", "F0 as program data", seq_state, 0);

        cur_req = "R5";
        wr(16'h00AA, 16'h0098);
        chk("R5", "query entry", seq_state, 9);
        wr(16'h0000, 16'h0012);
        chk("R5", "query exit", seq_state, 0);
        wr(16'h00AA, 16'h0098);
        cur_req = "R7";
        wr(16'h0000, 16'h00F0);
        chk("R7", "F0 from query", seq_state, 0);

        cur_req = "R6";
        unlock(); wr(16'h0AAA, 16'h0090);
        chk("R3", "autoselect", seq_state, 3);
        wr(16'h00AA, 16'h0098);
        chk("R6", "autoselect query", seq_state, 10);
        wr(16'h0000, 16'h00F0);
        chk("R6", "back to autoselect", seq_state, 3);
        wr(16'h0000, 16'h00F0);
        chk("R7", "F0 from autoselect", seq_state, 0);

        cur_req = "R9";
        unlock(); wr(16'h0AAA, 16'h0020);
        chk("R9", "bypass set", bypass_on, 1);
        wr(16'h0000, 16'h00A0);
        chk("R9", "program any key", seq_state, 4);
        wr(16'h0040, 16'h1234);
        chk("R9", "return to command", seq_state, 2);
        rd(16'h0040);
        chk("R8", "bypass program", rd_data, 16'h1234);
        cur_req = "R6";
        wr(16'h0100, 16'h0090);
        wr(16'h00AA, 16'h0098);
        wr(16'h0000, 16'h00F0);
        chk("R6", "flag kept", bypass_on, 1);
        cur_req = "R10";
        wr(16'h0000, 16'h0000);
        chk("R10", "bypass exit state", seq_state, 0);
        chk("R10", "bypass exit flag", bypass_on, 0);

        cur_req = "R13";
        unlock(); wr(16'h0AAA, 16'h0020);
        wr(16'h0000, 16'h0055);
        chk("R13", "mismatch clears flag", bypass_on, 0);

        cur_req = "R11";
        unlock(); wr(16'h0AAA, 16'h0080);
        chk("R11", "erase armed", seq_state, 5);
        unlock();
        wr(16'h0200, 16'h0030);
        chk("R11", "sector pulse", erase_sector_req, 1);
        chk("R11", "sector addr", erase_addr, 15'h0100);
        cur_req = "R12";
        wr(16'h0000, 16'h00F0);
        wr(16'h0AAA, 16'h00AA);
        chk("R12", "writes ignored", seq_state, 8);
        repeat (3) @(negedge clk);
        finish_erase();
        chk("R12", "erase done", seq_state, 0);

        cur_req = "R11";
        unlock(); wr(16'h0AAA, 16'h0080); unlock();
        wr(16'h0AAA, 16'h0010);
        chk("R11", "chip pulse", erase_chip_req, 1);
        finish_erase();
        unlock(); wr(16'h0AAA, 16'h0080);
        wr(16'h0AAA, 16'h0010);
        chk("R11", "no second unlock", seq_state, 0);
        unlock(); wr(16'h0AAA, 16'h0080); unlock();
        wr(16'h0100, 16'h0010);
        chk("R11", "chip off key", seq_state, 0);

        cur_req = "R12";
        unlock(); wr(16'h0AAA, 16'h0020);
        wr(16'h0300, 16'h0080); unlock();
        wr(16'h0AAA, 16'h0010);
        finish_erase();
        chk("R12", "bypass erase return", seq_state, 2);
        wr(16'h0000, 16'h00F0);
        chk("R7", "F0 clears bypass", bypass_on, 0);
        @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule